// File: doc/BRIEF.md
# Conditional PC-Relative Branch Resolver

This block resolves short conditional branches. Each cycle it looks at the current program counter, a 16-bit instruction word and the four arithmetic flags (carry, zero, negative, overflow). When the word belongs to the relative-branch format, the block tests the flags against the word's 3-bit condition code and decides whether the branch is taken. It then presents the address of the next instruction on a combinational output.

A taken branch lands at the sequential address plus a signed 10-bit word displacement. The sequential address is the PC advanced by one 2-byte word. A branch that is not taken, or a word that is not a branch, yields the sequential address. The flags are inputs only, and no path in the block drives them. A registered program counter copy loads the resolved address whenever the valid strobe is high and holds otherwise. A synchronous active-high reset sets this copy to a parameterised start address.

Top module: `br_resolve`

## Requirements
- R1: `is_branch` is 1 exactly when instruction bits [15:13] equal 3'b001.
- R2: The condition code in instruction bits [12:10] selects the test. 000 takes when Z=0, 001 when Z=1, 010 when C=0, 011 when C=1, 100 when N=1, 101 when N equals V, 110 when N differs from V, and 111 always. `taken` is 1 only when `is_branch` is 1 and the selected test holds.
- R3: When taken, `next_pc` equals the aligned PC plus 2 plus twice the sign-extended displacement held in instruction bits [9:0].
- R4: When not taken, including non-branch words, `next_pc` equals the aligned PC plus 2.
- R5: Bit 0 of `pc_in` is ignored and bit 0 of `next_pc` is always 0.
- R6: While `rst` is high at a clock edge, `pc_q` becomes RESET_PC.
- R7: At a clock edge with `valid` high, `pc_q` takes the current `next_pc`. With `valid` low, `pc_q` keeps its value.
- R8: Address arithmetic wraps modulo 2^16.
- R9: Displacement 10'h1FF reaches +512 words from the branch's own address, and 10'h200 reaches -511 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | 16 | Address of the current instruction |
| insn | input | 16 | Current instruction word |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| valid | input | 1 | Load strobe for the registered PC |
| is_branch | output | 1 | Instruction is of the relative-branch format |
| taken | output | 1 | Branch condition satisfied |
| next_pc | output | 16 | Resolved next instruction address |
| pc_q | output | 16 | Registered program counter |

## Verification
The bench keeps the default 16-bit address, 10-bit displacement and 3-bit condition widths, so every displacement and PC value is an actual hardware encoding. It overrides RESET_PC with 16'hC000, which separates the reset value from a zero-filled register. With these values the bench can sweep all eight condition codes across all sixteen flag combinations. It also reaches both displacement extremes and wrap-around at the top and bottom of the address space.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    BC_ZCLR  = 3'd0,
    BC_ZSET  = 3'd1,
    BC_CCLR  = 3'd2,
    BC_CSET  = 3'd3,
    BC_NSET  = 3'd4,
    BC_SGE   = 3'd5,
    BC_SLT   = 3'd6,
    BC_ALWAYS = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } br_flags_t;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          en,
  input  logic [CW-1:0] cond,
  input  br_flags_t     flags,
  output logic          take
);
  logic hit;

  always_comb begin
    unique case (br_cond_e'(cond))
      BC_ZCLR:   hit = ~flags.z;
      BC_ZSET:   hit = flags.z;
      BC_CCLR:   hit = ~flags.c;
      BC_CSET:   hit = flags.c;
      BC_NSET:   hit = flags.n;
      BC_SGE:    hit = ~(flags.n ^ flags.v);
      BC_SLT:    hit = flags.n ^ flags.v;
      default:   hit = 1'b1;
    endcase
  end

  assign take = en & hit;

  // R2: unconditional code must always take when enabled
  always_comb begin
    if (en && cond == CW'(BC_ALWAYS)) begin
      p_always_takes_r2: assert (take);
    end
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic [PC_W-1:0]  pc_raw,
  input  logic [OFF_W-1:0] disp,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  tgt_pc
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] pc_al;
  logic [PC_W-1:0] byte_disp;

  assign pc_al = pc_raw & ~PC_W'(1);

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_disp = {{EXT_W{disp[OFF_W-1]}}, disp, 1'b0};
    end else begin : g_trunc
      assign byte_disp = {disp[PC_W-2:0], 1'b0};
    end
  endgenerate

  assign seq_pc = pc_al + PC_W'(2);
  assign tgt_pc = seq_pc + byte_disp;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          INSN_W   = 16,
  parameter int          OFF_W    = 10,
  parameter int          CW       = 3,
  parameter logic [2:0]  FMT_CODE = 3'b001,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pc_in,
  input  logic [INSN_W-1:0] insn,
  input  logic            flag_c,
  input  logic            flag_z,
  input  logic            flag_n,
  input  logic            flag_v,
  input  logic            valid,
  output logic            is_branch,
  output logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] pc_q
);
  localparam int COND_LO = OFF_W;
  localparam int FMT_LO  = OFF_W + CW;
  localparam int FMT_W   = INSN_W - FMT_LO;

  logic [FMT_W-1:0] fmt;
  logic [CW-1:0]    cond;
  logic [OFF_W-1:0] disp;
  logic [PC_W-1:0]  seq_pc;
  logic [PC_W-1:0]  tgt_pc;
  br_flags_t        flags;

  assign fmt   = insn[INSN_W-1:FMT_LO];
  assign cond  = insn[FMT_LO-1:COND_LO];
  assign disp  = insn[OFF_W-1:0];
  assign flags = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v};

  assign is_branch = (fmt == FMT_W'(FMT_CODE));

  br_cond_eval #(.CW(CW)) u_cond (
    .en    (is_branch),
    .cond  (cond),
    .flags (flags),
    .take  (taken)
  );

  br_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_raw (pc_in),
    .disp   (disp),
    .seq_pc (seq_pc),
    .tgt_pc (tgt_pc)
  );

  assign next_pc = taken ? tgt_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= PC_W'(RESET_PC);
    end else if (valid) begin
      pc_q <= next_pc;
    end
  end

  // R1: a word outside the branch format never takes
  p_nonbranch_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !is_branch |-> !taken);

  // R4: fall-through address is one word past the instruction
  p_fallthru_r4: assert property (@(posedge clk) disable iff (rst)
    !taken |-> next_pc == ((pc_in & ~PC_W'(1)) + PC_W'(2)));

  // R5: resolved address stays word aligned
  p_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    next_pc[0] == 1'b0);

  // R7: strobe loads the resolved address
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> pc_q == $past(next_pc));

  // R7: without strobe the register holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(pc_q));
endmodule

// File: tb/br_resolve_bench.sv
module br_resolve_bench;
  localparam logic [15:0] RST_PC = 16'hC000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pc_in = '0;
  logic [15:0] insn = '0;
  logic        flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0;
  logic        valid = 1'b0;
  logic        is_branch, taken;
  logic [15:0] next_pc, pc_q;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  br_resolve #(.RESET_PC(RST_PC)) u_br_resolve (
    .clk(clk), .rst(rst), .pc_in(pc_in), .insn(insn),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .valid(valid), .is_branch(is_branch), .taken(taken),
    .next_pc(next_pc), .pc_q(pc_q)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_take(input logic [2:0] c, input logic fc, input logic fz,
                                      input logic fn, input logic fv);
    case (c)
      3'd0: return !fz;
      3'd1: return fz;
      3'd2: return !fc;
      3'd3: return fc;
      3'd4: return fn;
      3'd5: return fn == fv;
      3'd6: return fn != fv;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] model_next(input logic [15:0] pc, input logic [9:0] d, input logic tk);
    logic [15:0] base;
    base = {pc[15:1], 1'b0} + 16'd2;
    if (tk) return base + 16'({{6{d[9]}}, d} * 2);
    return base;
  endfunction

  task automatic drive(input logic [15:0] pc, input logic [15:0] w, input logic [3:0] f);
    @(negedge clk);
    pc_in = pc; insn = w;
    {flag_c, flag_z, flag_n, flag_v} = f;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R6 reset pc_q", pc_q, RST_PC);
  endtask

  task automatic t_format();
    for (int top = 0; top < 8; top++) begin
      drive(16'h1000, {3'(top), 3'b111, 10'h004}, 4'h0);
      check("R1 is_branch", {15'd0, is_branch}, {15'd0, top == 1});
      check("R4 nonbranch next", next_pc, top == 1 ? 16'h100A : 16'h1002);
    end
  endtask

  task automatic t_conditions();
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic tk;
        tk = model_take(3'(c), f[3], f[2], f[1], f[0]);
        drive(16'h2468, {3'b001, 3'(c), 10'h010}, 4'(f));
        check("R2 taken", {15'd0, taken}, {15'd0, tk});
        check(tk ? "R3 target" : "R4 fallthru", next_pc, model_next(16'h2468, 10'h010, tk));
      end
    end
  endtask

  task automatic t_extremes();
    drive(16'h8000, {6'b001111, 10'h1FF}, 4'h0);
    check("R9 max forward", next_pc, 16'h8000 + 16'd1024);
    drive(16'h8000, {6'b001111, 10'h200}, 4'h0);
    check("R9 max backward", next_pc, 16'h8000 - 16'd1022);
    drive(16'h8000, {6'b001111, 10'h3FF}, 4'h0);
    check("R3 minus one", next_pc, 16'h8000);
  endtask

  task automatic t_wrap();
    drive(16'hFFFE, {6'b001111, 10'h000}, 4'h0);
    check("R8 wrap up seq", next_pc, 16'h0000);
    drive(16'hFFFE, {6'b001111, 10'h005}, 4'h0);
    check("R8 wrap up tgt", next_pc, 16'h000A);
    drive(16'h0002, {6'b001111, 10'h3FC}, 4'h0);
    check("R8 wrap down", next_pc, 16'hFFFC);
    drive(16'hFFFE, {6'b000000, 10'h005}, 4'h0);
    check("R8 R4 wrap fallthru", next_pc, 16'h0000);
  endtask

  task automatic t_align();
    drive(16'h1235, {6'b001111, 10'h002}, 4'h0);
    check("R5 odd pc taken", next_pc, 16'h123A);
    drive(16'h1235, {6'b001001, 10'h002}, 4'h0);
    check("R5 odd pc fallthru", next_pc, 16'h1236);
  endtask

  task automatic t_register();
    drive(16'h3000, {6'b001111, 10'h008}, 4'h0);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    #1;
    check("R7 load", pc_q, 16'h3012);
    drive(16'h5000, {6'b001111, 10'h020}, 4'h0);
    @(negedge clk);
    #1;
    check("R7 hold", pc_q, 16'h3012);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R6 re-reset", pc_q, RST_PC);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_format();
    t_conditions();
    t_extremes();
    t_wrap();
    t_align();
    t_register();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule